// File: doc/BRIEF.md
# Dirty Scanline Band Merger

Once per display refresh this unit turns a stream of per-line dirty flags into a short list of horizontal redraw bands. Software or a preceding stage pulses `start_i` with the frame height, a flag saying whether the display mode is valid, and a flag saying whether the mode has changed since the previous refresh. While it scans, the unit takes one dirty flag per line over a valid/ready handshake. It merges each run of consecutive dirty lines into one record, made of a first line and a line count. It sends each record over a second valid/ready handshake.

Every band covers the whole display width, so a record carries only a line range. A mode change bypasses the scan and produces one record for the full frame. An invalid mode produces nothing. After the last record has been accepted, or when there is nothing to send, `done_o` pulses for one cycle.

Top module: `scanline_band_merger`

## Requirements
- R1: When `start_i` is sampled with `mode_valid_i`=1 and `mode_changed_i`=1, exactly one record with first line 0 and count equal to the height is emitted, and no dirty flags are consumed.
- R2: Otherwise, with a valid mode, exactly `height` dirty flags are consumed, in line order 0 to height-1.
- R3: A band opens at the first dirty line seen while no band is open, and the record's first line equals that line.
- R4: A band closes at the first clean line after it, and its record count equals that clean line's index minus the band's first line.
- R5: A band still open after line height-1 is emitted with a count of height minus its first line; no record extends past the frame.
- R6: When `start_i` is sampled with `mode_valid_i`=0, no record is produced and no dirty flag is consumed.
- R7: While a record is offered (`rec_valid_o`=1), `dirty_ready_o` is 0.
- R8: A record that is offered but not accepted stays offered, with first line and count unchanged.
- R9: `done_o` is high for exactly one cycle per refresh. It rises in the cycle after the last event of the refresh: the last record acceptance, or, when nothing is emitted, the last dirty flag taken or the start pulse itself.
- R10: After reset, `rec_valid_o`, `dirty_ready_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a refresh (accepted when idle) |
| height_i | input | LINE_W | Number of visible lines |
| mode_valid_i | input | 1 | Current mode is usable |
| mode_changed_i | input | 1 | Mode differs from the previous refresh |
| dirty_valid_i | input | 1 | Dirty flag for the next line is present |
| dirty_i | input | 1 | 1 when the current line needs redrawing |
| dirty_ready_o | output | 1 | Unit accepts a dirty flag this cycle |
| rec_valid_o | output | 1 | A band record is offered |
| rec_first_o | output | LINE_W | First line of the band |
| rec_count_o | output | LINE_W | Number of lines in the band |
| rec_ready_i | input | 1 | Consumer accepts the record |
| done_o | output | 1 | One-cycle end-of-refresh pulse |

## Verification
Every output is a register, so each handshake decided at a clock edge shows its effect at the next edge. A band record appears one cycle after the dirty flag that closes it, or one cycle after the start pulse in the full-frame case. The done pulse follows the last event of the refresh by one cycle. The bench drives inputs on the falling edge and then reads the outputs, which depend only on state. It logs every handshake for the coming rising edge and counts falling edges since the last logged event, so it can require the done pulse exactly one cycle later.

// File: rtl/scanline_band_merger.sv
module scanline_band_merger #(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LINE_W-1:0] height_i,
  input  logic              mode_valid_i,
  input  logic              mode_changed_i,
  input  logic              dirty_valid_i,
  input  logic              dirty_i,
  output logic              dirty_ready_o,
  output logic              rec_valid_o,
  output logic [LINE_W-1:0] rec_first_o,
  output logic [LINE_W-1:0] rec_count_o,
  input  logic              rec_ready_i,
  output logic              done_o
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_EMIT, S_DONE} state_t;

  state_t            state;
  logic [LINE_W-1:0] height_q, line_q, run_start_q, first_q, count_q;
  logic              run_open_q, fin_q;

  wire               last_line = (line_q == height_q - 1'b1);
  wire [LINE_W-1:0]  band_first = run_open_q ? run_start_q : line_q;

  assign dirty_ready_o = (state == S_SCAN);
  assign rec_valid_o   = (state == S_EMIT);
  assign done_o        = (state == S_DONE);
  assign rec_first_o   = first_q;
  assign rec_count_o   = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      height_q    <= '0;
      line_q      <= '0;
      run_start_q <= '0;
      first_q     <= '0;
      count_q     <= '0;
      run_open_q  <= 1'b0;
      fin_q       <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          height_q   <= height_i;
          line_q     <= '0;
          run_open_q <= 1'b0;
          if (!mode_valid_i) state <= S_DONE;
          else if (mode_changed_i) begin
            first_q <= '0;
            count_q <= height_i;
            fin_q   <= 1'b1;
            state   <= S_EMIT;
          end else if (height_i == '0) state <= S_DONE;
          else state <= S_SCAN;
        end
        S_SCAN: if (dirty_valid_i) begin
          line_q <= line_q + 1'b1;
          if (dirty_i) begin
            if (!run_open_q) begin
              run_open_q  <= 1'b1;
              run_start_q <= line_q;
            end
            if (last_line) begin
              first_q    <= band_first;
              count_q    <= height_q - band_first;
              fin_q      <= 1'b1;
              run_open_q <= 1'b0;
              state      <= S_EMIT;
            end
          end else if (run_open_q) begin
            first_q    <= run_start_q;
            count_q    <= line_q - run_start_q;
            fin_q      <= last_line;
            run_open_q <= 1'b0;
            state      <= S_EMIT;
          end else if (last_line) state <= S_DONE;
        end
        S_EMIT: if (rec_ready_i) state <= fin_q ? S_DONE : S_SCAN;
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> !dirty_ready_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o && !rec_ready_i |=> rec_valid_o && $stable(rec_first_o) && $stable(rec_count_o));

  assert_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid_o |-> ({1'b0, rec_first_o} + {1'b0, rec_count_o}) <= {1'b0, height_q});

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_no_take_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !dirty_ready_o);
endmodule

// File: tb/test_scanline_band_merger.sv
module test_scanline_band_merger;
  localparam int LW = 12;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, mode_valid_i = 0, mode_changed_i = 0;
  logic dirty_valid_i = 0, dirty_i = 0, rec_ready_i = 0;
  logic [LW-1:0] height_i = '0;
  logic dirty_ready_o, rec_valid_o, done_o;
  logic [LW-1:0] rec_first_o, rec_count_o;

  int compared = 0, mismatched = 0;
  logic [255:0] bits;
  int exp_first [256];
  int exp_cnt [256];
  int got_first [256];
  int got_cnt [256];
  int exp_n, got_n;

  always #5 clk = ~clk;

  scanline_band_merger #(.LINE_W(LW)) i_scanline_band_merger (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int h, input bit chg, input bit vld);
    int st;
    exp_n = 0;
    if (!vld) return;
    if (chg) begin exp_first[0] = 0; exp_cnt[0] = h; exp_n = 1; return; end
    st = -1;
    for (int y = 0; y < h; y++) begin
      if (bits[y] && st < 0) st = y;
      if (!bits[y] && st >= 0) begin
        exp_first[exp_n] = st; exp_cnt[exp_n] = y - st; exp_n++; st = -1;
      end
    end
    if (st >= 0) begin exp_first[exp_n] = st; exp_cnt[exp_n] = h - st; exp_n++; end
  endfunction

  task automatic frame(input int h, input bit chg, input bit vld, input int rdy_pct, input int dv_pct);
    int taken = 0, since = 0, dones = 0, cyc = 0;
    bit fin = 0;
    model(h, chg, vld);
    got_n = 0;
    @(negedge clk);
    start_i = 1; height_i = LW'(h); mode_changed_i = chg; mode_valid_i = vld;
    dirty_valid_i = 0; rec_ready_i = 0;
    while (!fin && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      start_i = 0;
      since++;
      if (done_o) begin
        dones++;
        chk("R9", "cycles from last event to done", since, 1);
        chk("R9", "records before done", got_n, exp_n);
        since = 0;
        fin = 1;
      end else begin
        dirty_valid_i = ($urandom_range(99) < dv_pct);
        dirty_i = (taken < 256) ? bits[taken] : 1'b0;
        rec_ready_i = ($urandom_range(99) < rdy_pct);
        #1;
        if (rec_valid_o && dirty_ready_o) chk("R7", "ready while record offered", 1, 0);
        if (dirty_valid_i && dirty_ready_o) begin
          if (taken >= h) chk("R2", "flag taken beyond height", taken, h - 1);
          taken++; since = 0;
        end
        if (rec_valid_o && rec_ready_i) begin
          if (got_n < 256) begin got_first[got_n] = rec_first_o; got_cnt[got_n] = rec_count_o; end
          got_n++; since = 0;
        end
      end
    end
    if (!fin) chk("R9", "watchdog: done never seen", 0, 1);
    @(negedge clk);
    chk("R9", "done is one cycle", done_o, 0);
    dirty_valid_i = 0; rec_ready_i = 0;
    chk(chg || !vld ? (vld ? "R1" : "R6") : "R2", "dirty flags consumed", taken, (vld && !chg) ? h : 0);
    chk(chg ? "R1" : (vld ? "R3" : "R6"), "record count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(chg ? "R1" : "R3", "first line", got_first[k], exp_first[k]);
      chk(chg ? "R1" : ((exp_first[k] + exp_cnt[k] == h) ? "R5" : "R4"), "band count", got_cnt[k], exp_cnt[k]);
    end
    chk("R9", "done pulses", dones, fin ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #12;
    chk("R10", "rec_valid after reset", rec_valid_o, 0);
    chk("R10", "dirty_ready after reset", dirty_ready_o, 0);
    chk("R10", "done after reset", done_o, 0);
    rst_n = 1;
    bits = '0;
    frame(100, 1, 1, 50, 100);                       // R1 full frame
    frame(100, 0, 0, 100, 100);                      // R6 invalid mode
    bits = '0; frame(80, 0, 1, 100, 100);            // R2 all clean
    bits = '1; frame(80, 0, 1, 30, 70);              // R5 whole frame one band
    bits = '0; bits[0] = 1; bits[63] = 1; frame(64, 0, 1, 100, 100); // R3/R5 edges
    bits = '0; bits[5] = 1; bits[6] = 1; bits[9] = 1; frame(12, 0, 1, 20, 100); // R4 stall
    bits = '1; frame(1, 0, 1, 100, 100);             // single line
    bits = '0; frame(0, 0, 1, 100, 100);             // empty frame
    for (int n = 0; n < 40; n++) begin
      for (int b = 0; b < 256; b++) bits[b] = ($urandom_range(99) < 45);
      frame($urandom_range(200) + 1, ($urandom_range(9) == 0), ($urandom_range(9) != 0),
            $urandom_range(90) + 10, $urandom_range(80) + 20);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL R9 watchdog expired: actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule